// File: doc/BRIEF.md
# Index-Based Round Robin Arbiter

This block shares one network-on-chip router output port among N requesters (four by default). All arbitration work is done on binary requester numbers instead of one-hot masks. A register holds the number of the last requester that won. The search for the next winner starts at the requester after that one and wraps around. The winner is found combinationally in the same cycle the requests are presented.

A zeroing stage forces the winning number to zero when no request is present. A decoder then expands that number into the one-hot grant vector. Because of this, an idle cycle never shows a grant left over from an earlier cycle. The router uses the binary grant number to steer its crossbar and the one-hot lines to acknowledge each requester.

Top module: `rr_index_arbiter`

## Requirements
- R1: `any_req` is high exactly when at least one bit of `req` is high, in the same cycle.
- R2: When `req` is all zero, `gnt` is all zero and `gnt_idx` is zero.
- R3: When any request is present, exactly one `gnt` bit is high, that bit is bit number `gnt_idx`, and that requester is asserting its request.
- R4: The winner is the first asserted request met when scanning upward from the last winner plus one, modulo N, with wrap-around. It is decided in the same cycle as the request, with no clock delay.
- R5: The last-winner register loads `gnt_idx` on every clock edge where a request is granted. On idle cycles it holds its value, so an idle gap does not change the rotation.
- R6: After synchronous active-low reset, requester 0 has the highest priority on the first arbitration.
- R7: A requester that holds its request continuously is granted within N cycles, whatever the other requesters do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_REQ | Request vector; bit i is requester i |
| gnt | output | NUM_REQ | One-hot grant vector; all zero when idle |
| gnt_idx | output | $clog2(NUM_REQ) | Binary number of the granted requester; zero when idle |
| any_req | output | 1 | High when any request bit is set |

## Verification
The bound checker checks on every cycle that the grant is one-hot, matches the index, and lies within the request vector. It also checks that an idle cycle gives an all-zero grant and zero index, that the winner moves on when the same contested request pattern is held, and that no held request waits N cycles. Only the bench's scenarios can show the exact winner order against the scan-from-last-winner rule. The same holds for the pointer keeping its value across idle gaps, the priority of requester 0 right after reset, and the even share of grants when every requester is active.

// File: rtl/rrx_pkg.sv
// Package rrx_pkg: shared helpers for the index-based round robin arbiter.
// Assumes requester counts fit in a 32-bit int.
package rrx_pkg;

    // Next requester number after idx in a ring of n entries.
    function automatic int wrap_inc(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rrx_cand_sel.sv
// rrx_cand_sel: for every possible search start, finds the first asserted
// request in circular order. The start after the stored last winner then picks
// one of those candidates through a final multiplexer.
// Assumes ptr_q < NUM_REQ. The output is only meaningful when some request is set.
module rrx_cand_sel #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [IDX_W-1:0]   ptr_q,
    output logic [IDX_W-1:0]   cand
);
    logic [NUM_REQ-1:0][IDX_W-1:0] per_start;
    logic [IDX_W-1:0]              start_idx;

    for (genvar s = 0; s < NUM_REQ; s++) begin : g_start
        logic [IDX_W-1:0] first_hit;
        // Scan from start s; the lowest circular offset wins, so scan downward.
        always_comb begin
            first_hit = IDX_W'(s);
            for (int k = NUM_REQ - 1; k >= 0; k--) begin
                if (req[(s + k) % NUM_REQ]) first_hit = IDX_W'((s + k) % NUM_REQ);
            end
        end
        assign per_start[s] = first_hit;
    end

    // Search begins one past the last winner, wrapping to zero.
    always_comb begin
        start_idx = IDX_W'(rrx_pkg::wrap_inc(int'(ptr_q), NUM_REQ));
        cand      = per_start[start_idx];
    end
endmodule

// File: rtl/rrx_zero_force.sv
// rrx_zero_force: builds the any-request flag and passes the candidate index
// only when some request is present. Otherwise the index is forced to zero.
module rrx_zero_force #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [IDX_W-1:0]   cand,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Request OR and zero-forcing select.
    always_comb begin
        any = |req;
        idx = any ? cand : '0;
    end
endmodule

// File: rtl/rrx_idx_decoder.sv
// rrx_idx_decoder: expands a binary index into a one-hot vector. The output is
// all zero when en is low, so no stale grant appears on idle cycles.
module rrx_idx_decoder #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_REQ-1:0] onehot
);
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
        // Line i is high only when enabled and the index equals i.
        assign onehot[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/rr_index_arbiter.sv
// rr_index_arbiter: N-requester round robin arbiter working on binary indices.
// A registered last-winner index sets where the next search starts. The grant
// is combinational from req. Assumes NUM_REQ >= 2 and a synchronous
// active-low reset.
module rr_index_arbiter #(
    parameter int NUM_REQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req,
    output logic [NUM_REQ-1:0]         gnt,
    output logic [$clog2(NUM_REQ)-1:0] gnt_idx,
    output logic                       any_req
);
    localparam int               IDX_W    = $clog2(NUM_REQ);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] cand;

    rrx_cand_sel #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_cand (
        .req   (req),
        .ptr_q (ptr_q),
        .cand  (cand)
    );

    rrx_zero_force #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_zero (
        .req  (req),
        .cand (cand),
        .any  (any_req),
        .idx  (gnt_idx)
    );

    rrx_idx_decoder #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_dec (
        .en     (any_req),
        .idx    (gnt_idx),
        .onehot (gnt)
    );

    // Last-winner register: resets to the top index so requester 0 is searched
    // first, and loads only on cycles that grant.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= LAST_IDX;
        else if (any_req) ptr_q <= gnt_idx;
    end
endmodule

// File: rtl/rr_index_arbiter_chk.sv
// rr_index_arbiter_chk: assertion checker bound to rr_index_arbiter.
// Observes ports only; the fairness window is tracked with per-requester counters.
module rr_index_arbiter_chk #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req,
    input logic [NUM_REQ-1:0] gnt,
    input logic [IDX_W-1:0]   gnt_idx,
    input logic               any_req
);
    localparam int CNT_W = $clog2(NUM_REQ) + 1;

    logic past_ok;

    // Marks that at least one cycle out of reset has passed, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (gnt == '0 && gnt_idx == '0));

    assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_req == (gnt != '0));

    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> ($countones(gnt) == 1 && gnt[gnt_idx] && (gnt & ~req) == '0));

    assert_rotates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(any_req) && $stable(req) && $countones(req) > 1)
            |-> (gnt_idx != $past(gnt_idx)));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_fair
        logic [CNT_W-1:0] wait_q;
        // Counts consecutive cycles requester i is kept waiting.
        always_ff @(posedge clk) begin
            if (!rst_n || !req[i] || gnt[i])      wait_q <= '0;
            else if (wait_q != {CNT_W{1'b1}})     wait_q <= wait_q + 1'b1;
        end
        assert_fair_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !gnt[i]) |-> (int'(wait_q) < NUM_REQ - 1));
    end
endmodule

bind rr_index_arbiter rr_index_arbiter_chk #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/rr_index_arbiter_bench.sv
// rr_index_arbiter_bench: vector table walk followed by directed reset and
// fairness tests. Inputs change at the falling edge; outputs are sampled 5 ns later.
module rr_index_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] gnt;
    logic [1:0] gnt_idx;
    logic       any_req;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    rr_index_arbiter #(.NUM_REQ(4)) u_rr_index_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req),
        .gnt(gnt), .gnt_idx(gnt_idx), .any_req(any_req)
    );

    always #10 clk = ~clk;

    // Vector: {req[3:0], expected gnt_idx[1:0]}; one entry per cycle from reset.
    localparam logic [5:0] VEC [17] = '{
        6'b0000_00, // idle after reset (R2)
        6'b1111_00, // all request, start at 0 (R6)
        6'b1111_01, 6'b1111_10, 6'b1111_11, // rotation (R4)
        6'b1111_00, // wrap (R4)
        6'b0000_00, // idle, last winner 0 held (R5)
        6'b0001_00, // start 1 wraps to 0 (R4)
        6'b1001_11, 6'b1001_00,
        6'b0110_01, 6'b0110_10,
        6'b0000_00, // idle, last winner 2 held (R5)
        6'b0101_00, // start 3 -> 0
        6'b0101_10, 6'b1000_11, 6'b0100_10
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt [4];
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #5;
        chk("R2 reset gnt", int'(gnt), 0);
        chk("R2 reset idx", int'(gnt_idx), 0);
        chk("R1 reset any", int'(any_req), 0);

        for (int v = 0; v < 17; v++) begin
            @(negedge clk) req = VEC[v][5:2];
            #5;
            chk("R4 idx", int'(gnt_idx), int'(VEC[v][1:0]));
            chk("R3 gnt", int'(gnt), (VEC[v][5:2] != 0) ? (1 << VEC[v][1:0]) : 0);
            chk("R1 any", int'(any_req), int'(VEC[v][5:2] != 0));
        end

        // R6: reset with last winner at 2; requester 0 must win first afterwards.
        @(negedge clk) begin rst_n = 1'b0; req = 4'b1111; end
        @(negedge clk) rst_n = 1'b1;
        #5;
        chk("R6 first after reset", int'(gnt_idx), 0);

        // R7: all requesters active for 8 cycles; each gets exactly two grants.
        foreach (cnt[j]) cnt[j] = 0;
        for (int c = 0; c < 8; c++) begin
            if (c != 0) begin
                @(negedge clk);
                #5;
            end
            chk("R3 onehot", $countones(gnt), 1);
            cnt[gnt_idx]++;
        end
        for (int j = 0; j < 4; j++) chk("R7 share", cnt[j], 2);

        // R5: idle gap of three cycles keeps the rotation (last winner 3 -> next 0).
        @(negedge clk) req = 4'b0000;
        repeat (3) @(negedge clk);
        req = 4'b0011;
        #5;
        chk("R5 hold across idle", int'(gnt_idx), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule